// File: doc/BRIEF.md
# Two-Phase Fork and Join Pipeline Stages

This block provides the two non-linear building pieces of a transition-signalled latch pipeline: a fork stage that hands one incoming bundle to several downstream consumers, and a join stage that gathers one bundle from each of several producers into a single outgoing bundle. Every port is a two-phase handshake. A producer announces a new item by toggling its request wire, with the data already stable. The consumer acknowledges by toggling its ack wire to the same phase. No wire returns to zero between items.

Inside, each stage is a capturing register whose enable is the XNOR of its own done phase and the merged downstream acknowledge. At the fork, a Muller C-element merges the branch acknowledges. At the join, a second C-element merges the source requests. A C-element output moves to the common value of its inputs only when they all agree, and otherwise holds. The design is a clocked model of the self-timed circuit. Every wire is sampled on the rising edge of `clk`, and every C-element and latch is one register.

Back-pressure works through the phases alone. A stage holds its item, and its request stays constant, until every consumer's ack phase matches that request. A producer may not change its request or its data while its ack phase differs from its request.

Top module: `tfj_fabric`

## Requirements
- R1: During and after reset, and before any request toggles, every request output, every ack output and every data output is 0.
- R2: A toggle on `fk_req_in` while the fork is empty (`fk_ack_out == fk_req_in` before the toggle) toggles every bit of `fk_req_out` one cycle later. At the same moment, each `W`-bit copy in `fk_data_out` takes the value of `fk_data_in`.
- R3: `fk_ack_out` always carries the phase of the item the fork holds. It toggles in the same cycle as `fk_req_out`.
- R4: While any branch ack `fk_ack_in[i]` differs from the fork's request phase, `fk_req_out`, `fk_ack_out` and `fk_data_out` stay unchanged, even if a new item is pending on `fk_req_in`.
- R5: Once the last branch acknowledges, a pending item is taken two cycles after that ack. One cycle is spent in the acknowledge C-element and one in the stage.
- R6: The join output `jn_req_out` toggles only after every `jn_req_in[i]` has toggled to the new phase. The toggle appears two cycles after the last source request changes, and never earlier.
- R7: When the join fires, `jn_data_out[i*W +: W]` equals the data word of source i that came with that item. Source 0 occupies the least significant bits.
- R8: Every bit of `jn_ack_out` equals the phase of the item the join holds, so all sources see their acknowledge in the cycle the join fires.
- R9: While `jn_ack_in` differs from `jn_req_out`, the join holds its output request and data. A complete set of source requests is taken one cycle after the downstream ack arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| fk_req_in | input | 1 | Fork upstream request phase |
| fk_data_in | input | W | Fork upstream data |
| fk_ack_out | output | 1 | Fork acknowledge phase to upstream |
| fk_req_out | output | NB | Request phase to each branch |
| fk_data_out | output | NB*W | Data copy for each branch |
| fk_ack_in | input | NB | Acknowledge phase from each branch |
| jn_req_in | input | NJ | Request phase from each source |
| jn_data_in | input | NJ*W | Data word of each source, source i at bits i*W |
| jn_ack_out | output | NJ | Acknowledge phase to each source |
| jn_req_out | output | 1 | Joined request phase to downstream |
| jn_data_out | output | NJ*W | Concatenated joined data |
| jn_ack_in | input | 1 | Downstream acknowledge phase |

## Verification
The fork's result is due one cycle after a request toggle into an empty stage. When an item is pending, the result is due two cycles after the last branch ack. The join's result is due two cycles after its last source toggle, or one cycle after a late downstream ack, whichever comes later. The bench sweeps every combination of per-branch ack delays and per-source request delays from 0 to 3 cycles, together with downstream ack delays of 0 to 2 cycles. For each combination it computes the cycle in which the output must toggle. It drives inputs and samples outputs on the falling edge, checks that the outputs stay steady in every cycle before that one, and checks the new phase and data exactly in that cycle.

// File: rtl/tfj_pkg.sv
package tfj_pkg;

  // A stage latch is open when its done phase equals the merged ack phase.
  function automatic logic phase_match(input logic a, input logic b);
    return ~(a ^ b);
  endfunction

endpackage

// File: rtl/tfj_celem.sv
module tfj_celem #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_ph,
  output logic         out_ph
);
  logic all_hi;
  logic all_lo;

  assign all_hi = &in_ph;
  assign all_lo = ~|in_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_ph <= 1'b0;
    else if (all_hi) out_ph <= 1'b1;
    else if (all_lo) out_ph <= 1'b0;
  end
endmodule

// File: rtl/tfj_stage.sv
module tfj_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_in,
  input  logic [W-1:0] data_in,
  input  logic         ack_in,
  output logic         done_ph,
  output logic [W-1:0] data_q
);
  import tfj_pkg::*;

  logic open_q;
  logic take;

  assign open_q = phase_match(done_ph, ack_in);
  assign take   = open_q && (req_in != done_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_ph <= 1'b0;
      data_q  <= '0;
    end else if (take) begin
      done_ph <= req_in;
      data_q  <= data_in;
    end
  end
endmodule

// File: rtl/tfj_fork.sv
module tfj_fork #(
  parameter int W  = 8,
  parameter int NB = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_in,
  input  logic [W-1:0]    data_in,
  output logic            ack_out,
  output logic [NB-1:0]   req_out,
  output logic [NB*W-1:0] data_out,
  input  logic [NB-1:0]   ack_in
);
  logic         ack_merged;
  logic         done_ph;
  logic [W-1:0] held;

  tfj_celem #(.N(NB)) u_ack_c (
    .clk(clk), .rst_n(rst_n), .in_ph(ack_in), .out_ph(ack_merged)
  );

  tfj_stage #(.W(W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .req_in(req_in), .data_in(data_in),
    .ack_in(ack_merged),
    .done_ph(done_ph), .data_q(held)
  );

  assign ack_out = done_ph;

  for (genvar b = 0; b < NB; b++) begin : g_branch
    assign req_out[b]          = done_ph;
    assign data_out[b*W +: W]  = held;
  end
endmodule

// File: rtl/tfj_join.sv
module tfj_join #(
  parameter int W  = 8,
  parameter int NJ = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NJ-1:0]   req_in,
  input  logic [NJ*W-1:0] data_in,
  output logic [NJ-1:0]   ack_out,
  output logic            req_out,
  output logic [NJ*W-1:0] data_out,
  input  logic            ack_in
);
  localparam int DW = NJ * W;

  logic req_merged;
  logic done_ph;

  tfj_celem #(.N(NJ)) u_req_c (
    .clk(clk), .rst_n(rst_n), .in_ph(req_in), .out_ph(req_merged)
  );

  tfj_stage #(.W(DW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .req_in(req_merged), .data_in(data_in),
    .ack_in(ack_in),
    .done_ph(done_ph), .data_q(data_out)
  );

  assign req_out = done_ph;

  for (genvar s = 0; s < NJ; s++) begin : g_src
    assign ack_out[s] = done_ph;
  end
endmodule

// File: rtl/tfj_fabric.sv
module tfj_fabric #(
  parameter int W  = 8,
  parameter int NB = 3,
  parameter int NJ = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fk_req_in,
  input  logic [W-1:0]    fk_data_in,
  output logic            fk_ack_out,
  output logic [NB-1:0]   fk_req_out,
  output logic [NB*W-1:0] fk_data_out,
  input  logic [NB-1:0]   fk_ack_in,
  input  logic [NJ-1:0]   jn_req_in,
  input  logic [NJ*W-1:0] jn_data_in,
  output logic [NJ-1:0]   jn_ack_out,
  output logic            jn_req_out,
  output logic [NJ*W-1:0] jn_data_out,
  input  logic            jn_ack_in
);
  tfj_fork #(.W(W), .NB(NB)) u_fork (
    .clk(clk), .rst_n(rst_n),
    .req_in(fk_req_in), .data_in(fk_data_in), .ack_out(fk_ack_out),
    .req_out(fk_req_out), .data_out(fk_data_out), .ack_in(fk_ack_in)
  );

  tfj_join #(.W(W), .NJ(NJ)) u_join (
    .clk(clk), .rst_n(rst_n),
    .req_in(jn_req_in), .data_in(jn_data_in), .ack_out(jn_ack_out),
    .req_out(jn_req_out), .data_out(jn_data_out), .ack_in(jn_ack_in)
  );
endmodule

// File: rtl/tfj_fabric_chk.sv
module tfj_fabric_chk #(
  parameter int W  = 8,
  parameter int NB = 3,
  parameter int NJ = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fk_req_in,
  input logic [W-1:0]    fk_data_in,
  input logic            fk_ack_out,
  input logic [NB-1:0]   fk_req_out,
  input logic [NB*W-1:0] fk_data_out,
  input logic [NB-1:0]   fk_ack_in,
  input logic [NJ-1:0]   jn_req_in,
  input logic [NJ*W-1:0] jn_data_in,
  input logic [NJ-1:0]   jn_ack_out,
  input logic            jn_req_out,
  input logic [NJ*W-1:0] jn_data_out,
  input logic            jn_ack_in
);
  // R2: a fork output toggle needs a pending upstream item one cycle earlier
  a_r2_fork_fires_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (fk_req_out[0] != $past(fk_req_out[0])) |-> ($past(fk_req_in) != $past(fk_ack_out)));

  // R2: data on a branch is the upstream word present when the item was taken
  a_r2_fork_data_bundled: assert property (@(posedge clk) disable iff (!rst_n)
    (fk_req_out[0] != $past(fk_req_out[0])) |-> (fk_data_out[W-1:0] == $past(fk_data_in)));

  // R4: an unacknowledged branch freezes the fork outputs
  a_r4_fork_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fk_ack_in != {NB{fk_req_out[0]}}) |=> ($stable(fk_req_out) && $stable(fk_data_out)
                                           && $stable(fk_ack_out)));

  // R6: the join fires only when every source had reached the new phase
  a_r6_join_waits_all: assert property (@(posedge clk) disable iff (!rst_n)
    (jn_req_out != $past(jn_req_out)) |-> ($past(jn_req_in, 2) == {NJ{jn_req_out}}));

  // R9: a missing downstream ack freezes the join outputs
  a_r9_join_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (jn_ack_in != jn_req_out) |=> ($stable(jn_req_out) && $stable(jn_data_out)));

  // R8: the source acks change only together with the joined request
  a_r8_join_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (jn_ack_out != $past(jn_ack_out)) |-> (jn_req_out != $past(jn_req_out)));
endmodule

bind tfj_fabric tfj_fabric_chk #(.W(W), .NB(NB), .NJ(NJ)) u_chk (.*);

// File: tb/tfj_fabric_bench.sv
module tfj_fabric_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int NB = 3;
  localparam int NJ = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            fk_req_in = 1'b0;
  logic [W-1:0]    fk_data_in = '0;
  logic            fk_ack_out;
  logic [NB-1:0]   fk_req_out;
  logic [NB*W-1:0] fk_data_out;
  logic [NB-1:0]   fk_ack_in = '0;
  logic [NJ-1:0]   jn_req_in = '0;
  logic [NJ*W-1:0] jn_data_in = '0;
  logic [NJ-1:0]   jn_ack_out;
  logic            jn_req_out;
  logic [NJ*W-1:0] jn_data_out;
  logic            jn_ack_in = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tfj_fabric #(.W(W), .NB(NB), .NJ(NJ)) u_tfj_fabric (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  function automatic logic [NB*W-1:0] rep(input logic [W-1:0] v);
    logic [NB*W-1:0] r;
    for (int b = 0; b < NB; b++) r[b*W +: W] = v;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] old_d;
    logic [W-1:0] new_d;
    logic         old_ph;
    logic [NJ*W-1:0] exp_j;
    logic [NJ*W-1:0] held_j;

    repeat (3) @(negedge clk);
    // R1: reset state while asserted
    check(fk_req_out == '0 && fk_ack_out == 1'b0 && fk_data_out == '0, "R1 fork in reset",
          {fk_req_out, fk_ack_out}, 0);
    check(jn_req_out == 1'b0 && jn_ack_out == '0 && jn_data_out == '0, "R1 join in reset",
          {jn_req_out, jn_ack_out}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(fk_req_out == '0 && fk_ack_out == 1'b0 && fk_data_out == '0, "R1 fork idle",
          fk_data_out, 0);
    check(jn_req_out == 1'b0 && jn_ack_out == '0 && jn_data_out == '0, "R1 join idle",
          jn_data_out, 0);

    // R2/R3: first item into the empty fork appears after one cycle
    fk_data_in = 8'hA5;
    fk_req_in  = 1'b1;
    @(negedge clk);
    check(fk_req_out == '1, "R2 first fork toggle", fk_req_out, '1);
    check(fk_data_out == rep(8'hA5), "R2 first fork data", fk_data_out, rep(8'hA5));
    check(fk_ack_out == 1'b1, "R3 fork ack phase", fk_ack_out, 1);

    // Fork sweep: every per-branch ack delay 0..3, next item always pending
    for (int idx = 0; idx < 64; idx++) begin
      int d [NB];
      int maxd;
      maxd = 0;
      for (int b = 0; b < NB; b++) begin
        d[b] = (idx >> (2*b)) & 3;
        if (d[b] > maxd) maxd = d[b];
      end
      old_ph = fk_req_out[0];
      old_d  = fk_data_out[W-1:0];
      new_d  = W'((idx * 29 + 11) & 8'hFF);
      for (int c = 0; c <= maxd + 2; c++) begin
        if (c > 0) @(negedge clk);
        if (c >= 1 && c <= maxd + 1) begin
          // R4: held while any branch has not acknowledged
          check(fk_req_out == {NB{old_ph}} && fk_data_out == rep(old_d) && fk_ack_out == old_ph,
                "R4 fork hold", {fk_req_out, fk_data_out}, {{NB{old_ph}}, rep(old_d)});
        end
        if (c == maxd + 2) begin
          // R5: pending item taken two cycles after the last branch ack
          check(fk_req_out == {NB{~old_ph}}, "R5 fork release cycle", fk_req_out, {NB{~old_ph}});
          check(fk_data_out == rep(new_d), "R2 fork data all branches", fk_data_out, rep(new_d));
          check(fk_ack_out == ~old_ph, "R3 fork ack toggles with req", fk_ack_out, ~old_ph);
        end
        if (c == 0) begin
          fk_req_in  = ~fk_req_in;
          fk_data_in = new_d;
        end
        for (int b = 0; b < NB; b++)
          if (d[b] == c) fk_ack_in[b] = old_ph;
      end
    end

    // Join sweep: per-source request delay 0..3, downstream ack delay 0..2
    held_j = '0;
    for (int idx = 0; idx < 192; idx++) begin
      int e [NJ];
      int k;
      int maxe;
      int fire;
      maxe = 0;
      k = idx / 64;
      for (int s = 0; s < NJ; s++) begin
        e[s] = (idx >> (2*s)) & 3;
        if (e[s] > maxe) maxe = e[s];
        exp_j[s*W +: W] = W'((idx * 13 + s * 71 + 3) & 8'hFF);
      end
      fire = (maxe + 2 > k + 1) ? maxe + 2 : k + 1;
      old_ph = jn_req_out;
      for (int c = 0; c <= fire; c++) begin
        if (c > 0) @(negedge clk);
        if (c >= 1 && c < fire) begin
          // R6 and R9: no early firing
          check(jn_req_out == old_ph && jn_data_out == held_j, "R6 join waits",
                {jn_req_out, jn_data_out}, {old_ph, held_j});
        end
        if (c == fire) begin
          check(jn_req_out == ~old_ph, "R9 join fire cycle", jn_req_out, ~old_ph);
          check(jn_data_out == exp_j, "R7 join concatenation", jn_data_out, exp_j);
          check(jn_ack_out == {NJ{~old_ph}}, "R8 join source acks", jn_ack_out, {NJ{~old_ph}});
        end
        if (c == k) jn_ack_in = old_ph;
        for (int s = 0; s < NJ; s++)
          if (e[s] == c) begin
            jn_req_in[s] = ~jn_req_in[s];
            jn_data_in[s*W +: W] = exp_j[s*W +: W];
          end
      end
      held_j = exp_j;
    end

    summary();
    $finish;
  end
endmodule